// File: doc/BRIEF.md
# DRAM ECC Error Status Logger

This block collects error reports from the ECC checkers of up to two DRAM channels and holds them until software has read them. Each report arrives as a one-cycle pulse that carries a correctable/uncorrectable flag, the column, row, bank and rank of the failing access, and the 8-bit syndrome. A shared status register summarises what has happened. It also records five side events from elsewhere in the memory controller: throttling, a locked access to non-DRAM space, a thermal event, and two isochronous FIFO conditions. Each channel keeps its own 64-bit log of a single error.

Capture follows a priority rule. An uncorrectable error may displace a logged correctable one. A correctable error never displaces anything, and a second error of the same kind leaves the first record in place. Software reads the registers through a simple word-addressed port. It clears status flags by writing ones to them. Clearing a flag also drops the matching flag in every channel log, which lets that log capture again. A strap input turns off the second channel. While the strap is set, channel 1 holds an empty log and its reports are ignored.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every register word (addresses 0 to 7) reads as zero.
- R2: Status word (address 0) bit 0 is set by a correctable report and bit 1 by an uncorrectable report from any enabled channel. Side events aux_evt[0..4] set bits 7, 9, 11, 13 and 14 in that order. All other bits always read as zero.
- R3: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a new event sets a bit in the same cycle as the write, the bit stays set.
- R4: A channel log reads as two 32-bit words. The low word holds bank in 31:29, rank in 28:27, syndrome in 23:16, the uncorrectable flag in bit 1 and the correctable flag in bit 0, with bits 26:24 and 15:2 zero. The high word holds column in 31:16 and row in 15:0.
- R5: A correctable report into an empty log captures its fields and sets the correctable flag. A further correctable report leaves the log unchanged.
- R6: An uncorrectable report into a log without the uncorrectable flag replaces all fields, sets the uncorrectable flag and clears the correctable flag.
- R7: While a log holds the uncorrectable flag, neither kind of report changes it.
- R8: Clearing status bit 0 or 1 clears the same flag in every channel log and leaves that log's fields as they were. A report in the same cycle is captured as if the log were empty of that flag.
- R9: Reports on both channels in the same cycle are each captured in their own log.
- R10: While dual_ch_dis is 1, the channel 1 log reads zero from the next cycle on, and channel 1 reports set no status bit.
- R11: Address map: 0 status, 1 and 2 channel 0 low and high, 3 and 4 channel 1 low and high. All other addresses read zero. Writes to any address other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_ch_dis | input | 1 | Strap: 1 turns off channel 1 |
| err_vld | input | NUM_CH | Per-channel report pulse |
| err_ue | input | NUM_CH | Per-channel report kind, 1 = uncorrectable |
| err_col | input | 16*NUM_CH | Column address, channel c in bits 16c+15:16c |
| err_row | input | 16*NUM_CH | Row address, packed by channel |
| err_bank | input | 3*NUM_CH | Bank address, packed by channel |
| err_rank | input | 2*NUM_CH | Rank within channel, packed by channel |
| err_synd | input | 8*NUM_CH | ECC syndrome, packed by channel |
| aux_evt | input | 5 | Side-event pulses: throttle, lock, thermal, FIFO put, FIFO full |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A wrong flag state in a channel log shows up one cycle after the offending report or write. It appears either in the low log word or in the next capture decision, where a later report is wrongly kept or wrongly dropped. Fields corrupted by an illegal overwrite appear in both log words on the cycle after capture. A status bit that fails to clear or set appears at address 0 on the next cycle. Because the read port is combinational, the bench compares the addressed word against its model on every clock, so a divergence is reported within one cycle of becoming visible.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYND_W = 8;
  localparam int REG_W  = 32;
  localparam int LOG_W  = 2 * REG_W;
  localparam int AUX_N  = 5;

  // status bit positions (decoded by software)
  localparam int ST_CE  = 0;
  localparam int ST_UE  = 1;
  localparam int ST_THR = 7;
  localparam int ST_LCK = 9;
  localparam int ST_THM = 11;
  localparam int ST_FPT = 13;
  localparam int ST_FFL = 14;
  localparam logic [REG_W-1:0] STS_IMPL =
    REG_W'((1 << ST_CE) | (1 << ST_UE) | (1 << ST_THR) | (1 << ST_LCK) |
           (1 << ST_THM) | (1 << ST_FPT) | (1 << ST_FFL));

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYND_W-1:0] synd;
  } err_info_t;

  // 64-bit log word: col|row|bank|rank|0|synd|0|ue|ce
  function automatic logic [LOG_W-1:0] pack_log(err_info_t i, logic ue, logic ce);
    return {i.col, i.row, i.bank, i.rank, 3'b000, i.synd, 14'b0, ue, ce};
  endfunction

  function automatic logic [REG_W-1:0] status_set(logic any_ce, logic any_ue,
                                                   logic [AUX_N-1:0] aux);
    logic [REG_W-1:0] s;
    s = '0;
    s[ST_CE]  = any_ce;
    s[ST_UE]  = any_ue;
    s[ST_THR] = aux[0];
    s[ST_LCK] = aux[1];
    s[ST_THM] = aux[2];
    s[ST_FPT] = aux[3];
    s[ST_FFL] = aux[4];
    return s;
  endfunction
endpackage

// File: rtl/ecc_chan_log.sv
module ecc_chan_log
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt_vld,
  input  logic             evt_ue,
  input  err_info_t        evt_info,
  input  logic             clr_ce,
  input  logic             clr_ue,
  output logic [LOG_W-1:0] log_word,
  output logic             ce_evt,
  output logic             ue_evt
);
  err_info_t info_q;
  logic      ce_q, ue_q;
  logic      ce_kept, ue_kept, take_ue, take_ce;

  assign ce_kept = ce_q & ~clr_ce;
  assign ue_kept = ue_q & ~clr_ue;
  assign take_ue = en & evt_vld & evt_ue & ~ue_kept;
  assign take_ce = en & evt_vld & ~evt_ue & ~ue_kept & ~ce_kept;
  assign ce_evt  = en & evt_vld & ~evt_ue;
  assign ue_evt  = en & evt_vld & evt_ue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= '0;
      ce_q   <= 1'b0;
      ue_q   <= 1'b0;
    end else if (!en) begin
      info_q <= '0;
      ce_q   <= 1'b0;
      ue_q   <= 1'b0;
    end else if (take_ue) begin
      info_q <= evt_info;
      ue_q   <= 1'b1;
      ce_q   <= 1'b0;
    end else if (take_ce) begin
      info_q <= evt_info;
      ce_q   <= 1'b1;
      ue_q   <= 1'b0;
    end else begin
      ce_q   <= ce_kept;
      ue_q   <= ue_kept;
    end
  end

  assign log_word = pack_log(info_q, ue_q, ce_q);

  // R5
  ce_first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ce_q && !clr_ce && evt_vld && !evt_ue) |=> (ce_q && $stable(info_q)));
  // R6
  ue_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && evt_vld && evt_ue && !ue_q) |=> (ue_q && !ce_q && info_q == $past(evt_info)));
  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ce_q, ue_q}));
  // R7
  ue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ue_q && !clr_ue) |=> (ue_q && !ce_q && $stable(info_q)));
  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_ce && !evt_vld) |=> !ce_q);
  // R10
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (log_word == '0));
endmodule

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] sts
);
  logic [REG_W-1:0] sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;
  end

  assign sts = sts_q;

  // R2
  set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0 && set_vec == '0) |=> $stable(sts_q));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dual_ch_dis,
  input  logic [NUM_CH-1:0]        err_vld,
  input  logic [NUM_CH-1:0]        err_ue,
  input  logic [NUM_CH*COL_W-1:0]  err_col,
  input  logic [NUM_CH*ROW_W-1:0]  err_row,
  input  logic [NUM_CH*BANK_W-1:0] err_bank,
  input  logic [NUM_CH*RANK_W-1:0] err_rank,
  input  logic [NUM_CH*SYND_W-1:0] err_synd,
  input  logic [AUX_N-1:0]         aux_evt,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata
);
  logic [LOG_W-1:0]  log_w [NUM_CH];
  logic [NUM_CH-1:0] ce_evt, ue_evt, ch_en;
  logic [REG_W-1:0]  sts_w, set_vec, clr_vec;
  logic              sts_wr;

  assign sts_wr  = reg_wr && (reg_addr == '0);
  assign clr_vec = sts_wr ? reg_wdata : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    err_info_t info;
    assign ch_en[c]  = (c == 0) ? 1'b1 : ~dual_ch_dis;
    assign info.col  = err_col [c*COL_W  +: COL_W];
    assign info.row  = err_row [c*ROW_W  +: ROW_W];
    assign info.bank = err_bank[c*BANK_W +: BANK_W];
    assign info.rank = err_rank[c*RANK_W +: RANK_W];
    assign info.synd = err_synd[c*SYND_W +: SYND_W];

    ecc_chan_log u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[c]),
      .evt_vld  (err_vld[c]),
      .evt_ue   (err_ue[c]),
      .evt_info (info),
      .clr_ce   (clr_vec[ST_CE]),
      .clr_ue   (clr_vec[ST_UE]),
      .log_word (log_w[c]),
      .ce_evt   (ce_evt[c]),
      .ue_evt   (ue_evt[c])
    );
  end

  assign set_vec = status_set(|ce_evt, |ue_evt, aux_evt);

  ecc_status_reg u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .sts     (sts_w)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = sts_w;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(2 * c + 1)) reg_rdata = log_w[c][REG_W-1:0];
      if (reg_addr == ADDR_W'(2 * c + 2)) reg_rdata = log_w[c][LOG_W-1:REG_W];
    end
  end

  // R10
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_ch_dis && NUM_CH > 1) |-> (ch_en == NUM_CH'(1)));
  // R11
  log_write_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != '0 && err_vld == '0 && !dual_ch_dis) |=> $stable(log_w[0]));
endmodule

// File: tb/tb_ecc_err_logger.sv
module tb_ecc_err_logger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_ch_dis = 1'b0;
  logic [1:0]  err_vld = '0, err_ue = '0;
  logic [15:0] t_col [2];
  logic [15:0] t_row [2];
  logic [2:0]  t_bank[2];
  logic [1:0]  t_rank[2];
  logic [7:0]  t_synd[2];
  logic [4:0]  aux_evt = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_sts;
  logic [63:0] m_log [2];

  always #5 clk = ~clk;

  ecc_err_logger dut (
    .clk(clk), .rst_n(rst_n), .dual_ch_dis(dual_ch_dis),
    .err_vld(err_vld), .err_ue(err_ue),
    .err_col({t_col[1], t_col[0]}), .err_row({t_row[1], t_row[0]}),
    .err_bank({t_bank[1], t_bank[0]}), .err_rank({t_rank[1], t_rank[0]}),
    .err_synd({t_synd[1], t_synd[0]}), .aux_evt(aux_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    logic [31:0] clr, nxt;
    logic [63:0] fresh;
    logic        ce, ue, on;
    if (!rst_n) begin
      m_sts = 0; m_log[0] = 0; m_log[1] = 0;
    end else begin
      clr = (reg_wr && reg_addr == 0) ? reg_wdata : 32'd0;
      nxt = m_sts & ~clr;
      for (int ch = 0; ch < 2; ch++) begin
        on = (ch == 0) || !dual_ch_dis;
        if (!on) m_log[ch] = 0;
        else begin
          ce = m_log[ch][0] && !clr[0];
          ue = m_log[ch][1] && !clr[1];
          fresh = (64'(t_col[ch]) << 48) | (64'(t_row[ch]) << 32) |
                  (64'(t_bank[ch]) << 29) | (64'(t_rank[ch]) << 27) |
                  (64'(t_synd[ch]) << 16);
          m_log[ch][1:0] = {ue, ce};
          if (err_vld[ch]) begin
            if (err_ue[ch]) nxt[1] = 1'b1; else nxt[0] = 1'b1;
            if (err_ue[ch] && !ue) m_log[ch] = fresh | 64'd2;
            else if (!err_ue[ch] && !ue && !ce) m_log[ch] = fresh | 64'd1;
          end
        end
      end
      if (aux_evt[0]) nxt[7] = 1'b1;
      if (aux_evt[1]) nxt[9] = 1'b1;
      if (aux_evt[2]) nxt[11] = 1'b1;
      if (aux_evt[3]) nxt[13] = 1'b1;
      if (aux_evt[4]) nxt[14] = 1'b1;
      m_sts = nxt;
    end
  end

  function automatic logic [31:0] model_word(logic [2:0] a);
    case (a)
      3'd0: return m_sts;
      3'd1: return m_log[0][31:0];
      3'd2: return m_log[0][63:32];
      3'd3: return m_log[1][31:0];
      3'd4: return m_log[1][63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-cycle comparison of the addressed word against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done)
      check(reg_addr == 0 ? "R2 model status" : "R4 model log", reg_rdata, model_word(reg_addr));
  end

  task automatic rd(logic [2:0] a, string req, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #3;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic load(int ch, logic ue, logic [15:0] c, logic [15:0] r,
                      logic [2:0] b, logic [1:0] k, logic [7:0] s);
    err_vld[ch] = 1; err_ue[ch] = ue;
    t_col[ch] = c; t_row[ch] = r; t_bank[ch] = b; t_rank[ch] = k; t_synd[ch] = s;
  endtask

  task automatic fire(int ch, logic ue, logic [15:0] c, logic [15:0] r,
                      logic [2:0] b, logic [1:0] k, logic [7:0] s);
    @(negedge clk);
    load(ch, ue, c, r, b, k, s);
    @(negedge clk);
    err_vld = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      t_col[i] = 0; t_row[i] = 0; t_bank[i] = 0; t_rank[i] = 0; t_synd[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R11: everything zero, unmapped addresses zero
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset word", 32'd0);

    // R5 / R4 / R2: correctable into empty log
    fire(0, 0, 16'h1234, 16'hABCD, 3'd5, 2'd2, 8'h5A);
    rd(1, "R4 ch0 low", 32'hB05A0001);
    rd(2, "R4 ch0 high", 32'h1234ABCD);
    rd(0, "R2 status ce", 32'h1);
    fire(0, 0, 16'h1111, 16'h2222, 3'd1, 2'd1, 8'h33);
    rd(1, "R5 second ce kept first", 32'hB05A0001);
    rd(2, "R5 second ce high", 32'h1234ABCD);

    // R6: uncorrectable displaces correctable
    fire(0, 1, 16'hBEEF, 16'h0042, 3'd1, 2'd3, 8'hC3);
    rd(1, "R6 ue low", 32'h38C30002);
    rd(2, "R6 ue high", 32'hBEEF0042);
    rd(0, "R2 status both", 32'h3);

    // R7: nothing displaces uncorrectable
    fire(0, 0, 16'h9999, 16'h8888, 3'd2, 2'd0, 8'h44);
    fire(0, 1, 16'h7777, 16'h6666, 3'd6, 2'd1, 8'h55);
    rd(1, "R7 ue held low", 32'h38C30002);
    rd(2, "R7 ue held high", 32'hBEEF0042);

    // R3 / R11: zero write and writes elsewhere do nothing
    wr(0, 32'h0);
    rd(0, "R3 zero write", 32'h3);
    wr(1, 32'hFFFFFFFF);
    wr(6, 32'hFFFFFFFF);
    rd(1, "R11 log write ignored", 32'h38C30002);
    rd(0, "R11 status untouched", 32'h3);
    wr(0, 32'h1);
    rd(0, "R3 clear bit0", 32'h2);

    // R8: clearing ue flag clears log flag, keeps fields, re-arms
    wr(0, 32'h2);
    rd(0, "R3 clear bit1", 32'h0);
    rd(1, "R8 flag dropped", 32'h38C30000);
    rd(2, "R8 fields kept", 32'hBEEF0042);
    fire(0, 0, 16'h0F0F, 16'h7777, 3'd7, 2'd0, 8'h01);
    rd(1, "R8 rearmed low", 32'hE0010001);
    rd(2, "R8 rearmed high", 32'h0F0F7777);

    // R9: both channels together
    @(negedge clk);
    load(0, 1, 16'hAAAA, 16'h5555, 3'd2, 2'd1, 8'h77);
    load(1, 0, 16'h0001, 16'h0002, 3'd3, 2'd2, 8'hFF);
    @(negedge clk);
    err_vld = '0;
    rd(1, "R9 ch0 low", 32'h48770002);
    rd(3, "R9 ch1 low", 32'h70FF0001);
    rd(4, "R9 ch1 high", 32'h00010002);
    rd(0, "R9 status", 32'h3);

    // R3 / R8: clear and new report in the same cycle
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h3;
    load(1, 0, 16'h3333, 16'h4444, 3'd0, 2'd0, 8'h10);
    @(negedge clk);
    reg_wr = 0; err_vld = '0;
    rd(0, "R3 set beats clear", 32'h1);
    rd(3, "R8 same-cycle capture", 32'h00100001);
    rd(4, "R8 same-cycle high", 32'h33334444);
    rd(1, "R8 ch0 flag dropped", 32'h48770000);

    // R2: side events
    @(negedge clk);
    aux_evt = 5'b11111;
    @(negedge clk);
    aux_evt = 0;
    rd(0, "R2 side bits", 32'h6A81);
    wr(0, 32'hFFFFFFFF);
    rd(0, "R3 clear all", 32'h0);

    // R10: strap
    @(negedge clk);
    dual_ch_dis = 1;
    rd(3, "R10 ch1 low cleared", 32'h0);
    rd(4, "R10 ch1 high cleared", 32'h0);
    fire(1, 1, 16'hFFFF, 16'hFFFF, 3'd7, 2'd3, 8'hEE);
    rd(0, "R10 ch1 no status", 32'h0);
    rd(3, "R10 ch1 no capture", 32'h0);
    fire(0, 1, 16'h0102, 16'h0304, 3'd4, 2'd1, 8'h20);
    rd(0, "R10 ch0 still active", 32'h2);
    @(negedge clk);
    dual_ch_dis = 0;
    fire(1, 0, 16'h5A5A, 16'hA5A5, 3'd1, 2'd2, 8'h08);
    rd(3, "R10 ch1 back", 32'h30080001);
    rd(4, "R10 ch1 back high", 32'h5A5AA5A5);
    rd(7, "R11 unmapped", 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule